// File: doc/BRIEF.md
# Descriptor-Driven Configuration Copy Engine

The block moves bytes out of an internal table of configuration items into system memory, or steps over them, as directed by a 16-byte descriptor that software places in memory. Software loads the physical address of that descriptor into a 64-bit pointer register, which it writes as two 32-bit halves. The write to the lower half starts the job. The engine then reads the descriptor over a simple request/acknowledge memory port. It copies or skips bytes of the currently selected item, starting at that item's running offset, and then writes a status word back into the first word of the descriptor.

A selector input picks the item and rewinds its offset to zero. Every item has a length derived from its selector number, and each byte's value is also computed from its selector and offset, so the table needs no storage. When a copy runs past the end of the item, or the memory port returns an error, the job stops with the error status. The offset then shows exactly how many bytes were moved. A constant feature word announces that the engine exists.

Top module: `cfgdma_engine`

## Requirements
- R1: The pointer register (`reg_ptr`) is zero after reset, and it goes back to zero once the status word of every job has been accepted.
- R2: A write with `reg_wr_hi`=1 only loads bits 63:32 of the pointer and starts nothing. A write with `reg_wr_hi`=0 loads bits 31:0 and starts a job. With `reg_wr_swap`=0 the data is stored as given. With `reg_wr_swap`=1 its four bytes are reversed before they are stored.
- R3: The descriptor is fetched as four 32-bit reads at pointer+0, +4, +8 and +12, in that order. These words hold control, length, target bits 63:32 and target bits 31:0. Each field is big-endian, and the port maps the byte at address offset k (addr[1:0]=k) to data bits 8k+7:8k. A request holds its address until it is acknowledged.
- R4: A control word with bit 1 set and bit 2 clear copies `length` bytes to ascending addresses from the target. Each byte is one write with a single strobe bit, on the lane that matches the target address. The item offset grows by one per byte. A length of zero gives success with no data write.
- R5: A control word with bit 2 set and bit 1 clear adds `length` to the item offset and writes no data.
- R6: Every job ends with exactly one full-strobe 32-bit write to the pointer address, and that write comes after all data writes. The value is 0 for success or 1 for error, big-endian, so the byte at pointer+3 is 0x01.
- R7: Item s is `ITEM_BASE + ITEM_STEP*s` bytes long (20 for s=3 with the defaults), and byte o of the item is (37*s + 3*o + 1) mod 256. A copy that reaches the end of the item stops with status 1. The offset is left at the item length.
- R8: If the memory port reports an error on a data write, the job stops with status 1, and the failed byte is not counted in the offset.
- R9: A control word with neither bit 1 nor bit 2 set, or with both set, ends with status 0. It writes no data and leaves the offset unchanged.
- R10: `feature_bits` reads 0x00000002: bit 1 set tells software the engine is present.
- R11: While `busy` is high, pointer writes and selector writes are ignored. A selector write while idle picks the item and sets its offset to 0.
- R12: A selector write in the same cycle as a starting low-half write takes effect first, so the job runs on the new item from offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Pointer register write strobe |
| reg_wr_hi | input | 1 | 1 = upper half, 0 = lower half (starts a job) |
| reg_wr_swap | input | 1 | 1 = reverse the data bytes (big-endian view) |
| reg_wr_data | input | 32 | Pointer half write data |
| reg_ptr | output | 64 | Current pointer register value |
| sel_wr_en | input | 1 | Selector write strobe |
| sel_wr_data | input | SEL_W | Item selector |
| feature_bits | output | 32 | Feature bitmap |
| busy | output | 1 | Job in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte strobes |
| mem_ack | input | 1 | Request completed |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_err | input | 1 | Request failed, valid with ack |

## Verification
A selector change can arrive in the same clock edge as the low-half pointer write that starts a job. In that case the rewind of the offset and the start of the job meet. The bench raises both strobes on one cycle and expects the bytes copied by that job to come from the new item at offset 0. The bench also collides a register write and a selector write with a running job. It then judges, through the bytes moved by the next job, that neither write changed the item or the offset.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

   localparam int PTR_W  = 64;
   localparam int WORD_W = 32;
   localparam int LANES  = WORD_W / 8;
   localparam int LANE_W = $clog2(LANES);

   localparam int CTL_READ = 1;
   localparam int CTL_SKIP = 2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_DISPATCH,
      ST_COPY,
      ST_WBACK
   } eng_state_t;

   function automatic logic [WORD_W-1:0] swap32(input logic [WORD_W-1:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

endpackage

// File: rtl/cfgdma_ptr_reg.sv
module cfgdma_ptr_reg
   import cfgdma_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_hi,
   input  logic              wr_swap,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              lock,
   input  logic              clear,
   output logic [PTR_W-1:0]  ptr,
   output logic              go
);

   localparam int HALVES = PTR_W / WORD_W;

   if (HALVES != 2) begin : g_bad_width
      $error("pointer must be exactly two words wide");
   end

   logic [WORD_W-1:0] half_val;

   assign half_val = wr_swap ? swap32(wr_data) : wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
         go  <= 1'b0;
      end else begin
         go <= 1'b0;
         if (clear) begin
            ptr <= '0;
         end else if (wr_en && !lock) begin
            if (wr_hi) begin
               ptr[PTR_W-1:WORD_W] <= half_val;
            end else begin
               ptr[WORD_W-1:0] <= half_val;
               go              <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cfgdma_cfg_store.sv
module cfgdma_cfg_store #(
   parameter int SEL_W     = 4,
   parameter int OFF_W     = 32,
   parameter int ITEM_BASE = 8,
   parameter int ITEM_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_data,
   input  logic             adv,
   input  logic             skip_en,
   input  logic [OFF_W-1:0] skip_len,
   output logic [OFF_W-1:0] offset,
   output logic [OFF_W-1:0] item_len,
   output logic [7:0]       cur_byte,
   output logic             in_range
);

   localparam int BYTE_MUL = 37;
   localparam int OFF_MUL  = 3;

   if (ITEM_BASE < 1) begin : g_bad_base
      $error("ITEM_BASE must be at least one byte");
   end
   if (SEL_W < 1 || SEL_W > 16) begin : g_bad_sel
      $error("SEL_W out of range");
   end

   logic [SEL_W-1:0] sel_q;

   if (ITEM_STEP == 0) begin : g_fixed_len
      assign item_len = OFF_W'(ITEM_BASE);
   end else begin : g_scaled_len
      assign item_len = OFF_W'(ITEM_BASE) + OFF_W'(ITEM_STEP) * OFF_W'(sel_q);
   end

   assign in_range = offset < item_len;
   assign cur_byte = 8'(8'(sel_q) * 8'(BYTE_MUL) + 8'(offset) * 8'(OFF_MUL) + 8'd1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         offset <= '0;
      end else if (sel_wr) begin
         sel_q  <= sel_data;
         offset <= '0;
      end else if (skip_en) begin
         offset <= offset + skip_len;
      end else if (adv) begin
         offset <= offset + 1'b1;
      end
   end

   AST_SEL_NOT_WITH_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |-> !adv && !skip_en); // R11

endmodule

// File: rtl/cfgdma_engine_fsm.sv
module cfgdma_engine_fsm
   import cfgdma_pkg::*;
#(
   parameter int OFF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [PTR_W-1:0]  ptr,
   input  logic              in_range,
   input  logic [7:0]        cur_byte,
   output logic              adv,
   output logic              skip_en,
   output logic [OFF_W-1:0]  skip_len,
   output logic              done,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PTR_W-1:0]  mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   output logic [LANES-1:0]  mem_be,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   input  logic              mem_err
);

   if (OFF_W < WORD_W) begin : g_bad_off
      $error("OFF_W must hold a full descriptor length");
   end

   eng_state_t        state;
   logic [PTR_W-1:0]  base_q;
   logic [PTR_W-1:0]  tgt_q;
   logic [WORD_W-1:0] len_q;
   logic [1:0]        widx;
   logic              op_rd_q;
   logic              op_sk_q;
   logic              err_q;
   logic [WORD_W-1:0] copy_word;
   logic [WORD_W-1:0] fetched;
   logic              op_read;
   logic              op_skip;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign copy_word[8*l +: 8] = cur_byte;
   end

   assign fetched  = swap32(mem_rdata);
   assign op_read  = op_rd_q && !op_sk_q;
   assign op_skip  = op_sk_q && !op_rd_q;
   assign skip_len = OFF_W'(len_q);
   assign busy     = state != ST_IDLE;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = base_q;
      mem_be    = '1;
      mem_wdata = swap32({{(WORD_W-1){1'b0}}, err_q});
      adv       = 1'b0;
      skip_en   = 1'b0;
      done      = 1'b0;
      case (state)
         ST_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = base_q + PTR_W'({widx, 2'b00});
         end
         ST_DISPATCH: skip_en = op_skip;
         ST_COPY: begin
            if (in_range) begin
               mem_req   = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = tgt_q;
               mem_be    = LANES'(1) << tgt_q[LANE_W-1:0];
               mem_wdata = copy_word;
               adv       = mem_ack && !mem_err;
            end
         end
         ST_WBACK: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
            done    = mem_ack;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         base_q  <= '0;
         tgt_q   <= '0;
         len_q   <= '0;
         widx    <= '0;
         op_rd_q <= 1'b0;
         op_sk_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (go) begin
                  base_q <= ptr;
                  widx   <= '0;
                  err_q  <= 1'b0;
                  state  <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     err_q <= 1'b1;
                     state <= ST_WBACK;
                  end else begin
                     case (widx)
                        2'd0: begin
                           op_rd_q <= fetched[CTL_READ];
                           op_sk_q <= fetched[CTL_SKIP];
                        end
                        2'd1:    len_q                <= fetched;
                        2'd2:    tgt_q[PTR_W-1:WORD_W] <= fetched;
                        default: tgt_q[WORD_W-1:0]     <= fetched;
                     endcase
                     widx <= widx + 2'd1;
                     if (widx == 2'd3) state <= ST_DISPATCH;
                  end
               end
            end
            ST_DISPATCH: begin
               state <= (op_read && len_q != '0) ? ST_COPY : ST_WBACK;
            end
            ST_COPY: begin
               if (!in_range) begin
                  err_q <= 1'b1;
                  state <= ST_WBACK;
               end else if (mem_ack) begin
                  if (mem_err) begin
                     err_q <= 1'b1;
                     state <= ST_WBACK;
                  end else begin
                     tgt_q <= tgt_q + 1'b1;
                     len_q <= len_q - 1'b1;
                     if (len_q == 1) state <= ST_WBACK;
                  end
               end
            end
            ST_WBACK: begin
               if (mem_ack) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3

   AST_COPY_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && state == ST_COPY |-> $countones(mem_be) == 1 && mem_be[mem_addr[LANE_W-1:0]]); // R4

   AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && state == ST_WBACK |-> mem_addr == base_q && mem_be == '1
         && (mem_wdata == '0 || mem_wdata == 32'h0100_0000)); // R6

   AST_DONE_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R6

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
   import cfgdma_pkg::*;
#(
   parameter int SEL_W     = 4,
   parameter int OFF_W     = 32,
   parameter int ITEM_BASE = 8,
   parameter int ITEM_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_wr_hi,
   input  logic              reg_wr_swap,
   input  logic [31:0]       reg_wr_data,
   output logic [63:0]       reg_ptr,
   input  logic              sel_wr_en,
   input  logic [SEL_W-1:0]  sel_wr_data,
   output logic [31:0]       feature_bits,
   output logic              busy,
   output logic              mem_req,
   output logic              mem_we,
   output logic [63:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [3:0]        mem_be,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_err
);

   localparam logic [31:0] FEATURES = 32'h0000_0002;

   logic             go;
   logic             done;
   logic             fsm_busy;
   logic             adv;
   logic             skip_en;
   logic [OFF_W-1:0] skip_len;
   logic [OFF_W-1:0] offset;
   logic [OFF_W-1:0] item_len;
   logic [7:0]       cur_byte;
   logic             in_range;

   assign busy         = fsm_busy | go;
   assign feature_bits = FEATURES;

   cfgdma_ptr_reg i_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wr_hi   (reg_wr_hi),
      .wr_swap (reg_wr_swap),
      .wr_data (reg_wr_data),
      .lock    (busy),
      .clear   (done),
      .ptr     (reg_ptr),
      .go      (go)
   );

   cfgdma_cfg_store #(
      .SEL_W     (SEL_W),
      .OFF_W     (OFF_W),
      .ITEM_BASE (ITEM_BASE),
      .ITEM_STEP (ITEM_STEP)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_wr   (sel_wr_en && !busy),
      .sel_data (sel_wr_data),
      .adv      (adv),
      .skip_en  (skip_en),
      .skip_len (skip_len),
      .offset   (offset),
      .item_len (item_len),
      .cur_byte (cur_byte),
      .in_range (in_range)
   );

   cfgdma_engine_fsm #(
      .OFF_W (OFF_W)
   ) i_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .ptr       (reg_ptr),
      .in_range  (in_range),
      .cur_byte  (cur_byte),
      .adv       (adv),
      .skip_en   (skip_en),
      .skip_len  (skip_len),
      .done      (done),
      .busy      (fsm_busy),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_be    (mem_be),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .mem_err   (mem_err)
   );

   AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> reg_ptr == '0); // R1

   AST_COPY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_be != 4'hF |-> offset < item_len); // R7

   AST_GO_STARTS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> mem_req && !mem_we && mem_addr == reg_ptr); // R3

endmodule

// File: tb/test_cfgdma_engine.sv
module test_cfgdma_engine;

   localparam int SEL_W = 4;
   localparam int IB    = 8;
   localparam int IS    = 4;

   typedef struct {
      logic [63:0] addr;
      logic [31:0] data;
      logic [3:0]  be;
      string       tag;
   } wr_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0, reg_wr_hi = 1'b0, reg_wr_swap = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [63:0] reg_ptr;
   logic        sel_wr_en = 1'b0;
   logic [SEL_W-1:0] sel_wr_data = '0;
   logic [31:0] feature_bits;
   logic        busy;
   logic        mem_req, mem_we;
   logic [63:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [3:0]  mem_be;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_err = 1'b0;

   int vectors = 0;
   int miscompares = 0;
   int model_sel = 0;
   int model_off = 0;
   logic        err_armed = 1'b0;
   logic [63:0] err_addr = '0;
   logic [7:0]  mem [logic [63:0]];
   wr_item_t    expq [$];

   always #2.5 clk = ~clk;

   cfgdma_engine i_cfgdma_engine (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_hi(reg_wr_hi), .reg_wr_swap(reg_wr_swap),
      .reg_wr_data(reg_wr_data), .reg_ptr(reg_ptr),
      .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
      .feature_bits(feature_bits), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err)
   );

   function automatic logic [7:0] exp_byte(int s, int o);
      return 8'(s * 37 + o * 3 + 1);
   endfunction

   function automatic logic [7:0] rd_mem(logic [63:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Memory model and scoreboard monitor
   initial begin
      forever begin
         @(posedge clk);
         if (mem_req && !mem_ack) begin
            if (err_armed && mem_addr == err_addr) begin
               err_armed = 1'b0;
               mem_err <= 1'b1;
            end else begin
               mem_err <= 1'b0;
               if (mem_we) begin
                  if (expq.size() == 0) begin
                     vectors++;
                     miscompares++;
                     $display("FAIL R6: unexpected write addr %h data %h, expected none", mem_addr, mem_wdata);
                  end else begin
                     wr_item_t it;
                     logic [31:0] m;
                     it = expq.pop_front();
                     m = {{8{it.be[3]}}, {8{it.be[2]}}, {8{it.be[1]}}, {8{it.be[0]}}};
                     check(mem_addr == it.addr && mem_be == it.be && (mem_wdata & m) == (it.data & m),
                           it.tag, {mem_addr[31:0], mem_wdata}, {it.addr[31:0], it.data});
                  end
                  for (int k = 0; k < 4; k++)
                     if (mem_be[k]) mem[{mem_addr[63:2], 2'(k)}] = mem_wdata[8*k +: 8];
               end else begin
                  mem_rdata <= {rd_mem(mem_addr + 3), rd_mem(mem_addr + 2),
                                rd_mem(mem_addr + 1), rd_mem(mem_addr)};
               end
            end
            mem_ack <= 1'b1;
         end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
         end
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   task automatic put_desc(logic [63:0] base, logic [31:0] ctl, logic [31:0] len, logic [63:0] tgt);
      logic [127:0] d;
      d = {ctl, len, tgt};
      for (int k = 0; k < 16; k++) mem[base + 64'(k)] = d[127 - 8*k -: 8];
   endtask

   task automatic reg_write(bit hi, bit swap, logic [31:0] v);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_hi = hi; reg_wr_swap = swap;
      reg_wr_data = swap ? {v[7:0], v[15:8], v[23:16], v[31:24]} : v;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic sel_write(int s);
      @(negedge clk);
      sel_wr_en = 1'b1; sel_wr_data = SEL_W'(s);
      @(negedge clk);
      sel_wr_en = 1'b0;
      model_sel = s; model_off = 0;
   endtask

   task automatic push_copy(logic [63:0] tgt, int n, string tag);
      for (int k = 0; k < n; k++) begin
         wr_item_t it;
         logic [63:0] a;
         a = tgt + 64'(k);
         it.addr = a; it.data = {4{exp_byte(model_sel, model_off)}};
         it.be = 4'(1) << a[1:0]; it.tag = tag;
         expq.push_back(it);
         model_off++;
      end
   endtask

   task automatic push_status(logic [63:0] base, bit err, string tag);
      wr_item_t it;
      it.addr = base; it.data = err ? 32'h0100_0000 : 32'h0; it.be = 4'hF; it.tag = tag;
      expq.push_back(it);
   endtask

   task automatic wait_done(string tag);
      repeat (2) @(negedge clk);
      while (busy) @(negedge clk);
      check(reg_ptr == 64'h0, "R1", reg_ptr, 64'h0);
      check(expq.size() == 0, tag, 64'(expq.size()), 64'h0);
   endtask

   task automatic run_op(logic [63:0] base, bit swap, string tag);
      reg_write(1'b1, swap, base[63:32]);
      reg_write(1'b0, swap, base[31:0]);
      wait_done(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 / R10 reset state
      check(reg_ptr == 64'h0, "R1", reg_ptr, 64'h0);
      check(busy == 1'b0, "R1", 64'(busy), 64'h0);
      check(feature_bits == 32'h2, "R10", 64'(feature_bits), 64'h2);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 basic read, unaligned target, item 3 (20 bytes)
      sel_write(3);
      put_desc(64'h1000, 32'h2, 32'd5, 64'h2001);
      push_copy(64'h2001, 5, "R4");
      push_status(64'h1000, 1'b0, "R6");
      run_op(64'h1000, 1'b0, "R4");

      // R5 skip 6, then read 2 shows advanced offset
      put_desc(64'h1010, 32'h4, 32'd6, 64'h3000);
      push_status(64'h1010, 1'b0, "R5");
      run_op(64'h1010, 1'b0, "R5");
      model_off += 6;
      put_desc(64'h1020, 32'h2, 32'd2, 64'h2100);
      push_copy(64'h2100, 2, "R5");
      push_status(64'h1020, 1'b0, "R5");
      run_op(64'h1020, 1'b0, "R5");

      // R9 neither / both bits, then R4 zero length
      put_desc(64'h1030, 32'h0, 32'd4, 64'h2200);
      push_status(64'h1030, 1'b0, "R9");
      run_op(64'h1030, 1'b0, "R9");
      put_desc(64'h1040, 32'h6, 32'd4, 64'h2200);
      push_status(64'h1040, 1'b0, "R9");
      run_op(64'h1040, 1'b0, "R9");
      put_desc(64'h1050, 32'h2, 32'd0, 64'h2200);
      push_status(64'h1050, 1'b0, "R4");
      run_op(64'h1050, 1'b0, "R4");
      put_desc(64'h1060, 32'h2, 32'd1, 64'h2200);
      push_copy(64'h2200, 1, "R9");
      push_status(64'h1060, 1'b0, "R9");
      run_op(64'h1060, 1'b0, "R9");

      // R7 overrun: offset 14 of 20, ask for 10
      put_desc(64'h1070, 32'h2, 32'd10, 64'h2300);
      push_copy(64'h2300, 20 - model_off, "R7");
      push_status(64'h1070, 1'b1, "R7");
      run_op(64'h1070, 1'b0, "R7");
      check(rd_mem(64'h1073) == 8'h01, "R6", 64'(rd_mem(64'h1073)), 64'h1);
      put_desc(64'h1080, 32'h2, 32'd1, 64'h2400);
      push_status(64'h1080, 1'b1, "R7");
      run_op(64'h1080, 1'b0, "R7");

      // R8 memory error on third byte
      sel_write(1);
      put_desc(64'h1090, 32'h2, 32'd5, 64'h2500);
      push_copy(64'h2500, 2, "R8");
      push_status(64'h1090, 1'b1, "R8");
      err_armed = 1'b1; err_addr = 64'h2502;
      run_op(64'h1090, 1'b0, "R8");
      put_desc(64'h10A0, 32'h2, 32'd1, 64'h2600);
      push_copy(64'h2600, 1, "R8");
      push_status(64'h10A0, 1'b0, "R8");
      run_op(64'h10A0, 1'b0, "R8");

      // R2 / R3 64-bit pointer and target through the byte-reversed view
      put_desc(64'h2_0000_0040, 32'h2, 32'd3, 64'h1_0000_0301);
      push_copy(64'h1_0000_0301, 3, "R3");
      push_status(64'h2_0000_0040, 1'b0, "R3");
      run_op(64'h2_0000_0040, 1'b1, "R2");

      // R2 upper-half write alone starts nothing
      reg_write(1'b1, 1'b0, 32'hABCD);
      repeat (6) @(negedge clk);
      check(busy == 1'b0, "R2", 64'(busy), 64'h0);
      check(reg_ptr == 64'h0000_ABCD_0000_0000, "R2", reg_ptr, 64'h0000_ABCD_0000_0000);
      put_desc(64'h0000_ABCD_0000_1100, 32'h0, 32'd0, 64'h0);
      push_status(64'h0000_ABCD_0000_1100, 1'b0, "R2");
      reg_write(1'b0, 1'b0, 32'h1100);
      wait_done("R2");

      // R11 writes during a job are ignored
      put_desc(64'h10B0, 32'h2, 32'd4, 64'h2700);
      push_copy(64'h2700, 4, "R11");
      push_status(64'h10B0, 1'b0, "R11");
      reg_write(1'b1, 1'b0, 32'h0);
      reg_write(1'b0, 1'b0, 32'h10B0);
      repeat (3) @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_hi = 1'b0; reg_wr_swap = 1'b0; reg_wr_data = 32'h5000;
      sel_wr_en = 1'b1; sel_wr_data = SEL_W'(7);
      @(negedge clk);
      reg_wr_en = 1'b0; sel_wr_en = 1'b0;
      wait_done("R11");
      repeat (6) @(negedge clk);
      check(busy == 1'b0, "R11", 64'(busy), 64'h0);
      put_desc(64'h10C0, 32'h2, 32'd2, 64'h2800);
      push_copy(64'h2800, 2, "R11");
      push_status(64'h10C0, 1'b0, "R11");
      run_op(64'h10C0, 1'b0, "R11");

      // R12 selector write in the same cycle as the starting write
      put_desc(64'h10D0, 32'h2, 32'd3, 64'h2900);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_hi = 1'b0; reg_wr_swap = 1'b0; reg_wr_data = 32'h10D0;
      sel_wr_en = 1'b1; sel_wr_data = SEL_W'(2);
      model_sel = 2; model_off = 0;
      push_copy(64'h2900, 3, "R12");
      push_status(64'h10D0, 1'b0, "R12");
      @(negedge clk);
      reg_wr_en = 1'b0; sel_wr_en = 1'b0;
      wait_done("R12");

      summary();
   end

endmodule